// File: doc/BRIEF.md
# Register-Mapped Up-Counter with Wrap Interrupt

This block puts a small 8-bit counter behind an AXI4-Lite slave port. Software programs a preset value and a two-bit operating code. It then reads back the running count and a sticky wrap flag. The count also drives an 8-bit output port continuously, for example to a row of indicator lamps.

When the counter wraps from its top value to zero while counting up, the flag is set and raises the interrupt output. The flag stays set until software clears it with a register write. The block runs on the bus clock and is reset by the active-low bus reset.

Top module: `cntp_top`

## Requirements
- R1: After reset the count is 0, the lamp output is 0, the interrupt is low, and neither BVALID nor RVALID is asserted.
- R2: The word index is address bits [6:2], giving a window of 32 word registers. Address bits [1:0] are ignored.
- R3: Bits [7:0] of word 0 hold the preset value. A read of word 0 returns the live count in bits [7:0], with bits [31:8] zero.
- R4: Bits [1:0] of word 1 select the operating code, which acts on every clock. 00 holds the count, 01 adds one, 10 copies the preset, and 11 forces the count to zero.
- R5: The lamp output equals the count at all times.
- R6: Words 1 and 2 read back what was written to them. Each write updates only the byte lanes whose WSTRB bit is 1.
- R7: In code 01, a step from 0xFF to 0x00 sets the wrap flag. The interrupt output equals the flag, and bit 0 of word 3 reads the flag.
- R8: A write of 1 to bit 1 of word 3 clears the flag. A write to word 3 with bit 1 at 0 leaves the flag unchanged.
- R9: If a wrap and a clear fall in the same cycle, the flag ends up set.
- R10: Every response is OKAY (00). Only one write and one read are in flight at a time. BVALID stays high until BREADY, and RVALID and RDATA stay unchanged until RREADY.
- R11: Words 4 to 31 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 7 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 7 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| led_o | output | 8 | Live count to the lamp port |
| irq_o | output | 1 | Wrap interrupt, equal to the flag |

## Verification
A wrong count or a wrong operating code shows on the lamp port at the very next clock. The bench holds the counter in code 00 and reads the port at known edges, so the expected value is exact. A stale flag, or a wrong priority between set and clear, shows on the interrupt line one cycle after the wrap edge. A bad read decode or a broken byte-lane merge shows only when the register is next read back, so the bench reads back after every kind of write.

// File: rtl/cntp_pkg.sv
package cntp_pkg;
    parameter int DATA_W    = 32;
    parameter int CNT_W     = 8;
    parameter int NUM_WORDS = 32;

    localparam int IDX_W  = $clog2(NUM_WORDS);
    localparam int LSB    = $clog2(DATA_W / 8);
    localparam int ADDR_W = IDX_W + LSB;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_UP   = 2'b01,
        OP_LOAD = 2'b10,
        OP_ZERO = 2'b11
    } op_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/cntp_core.sv
module cntp_core
    import cntp_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  op_e          op_i,
    input  logic [W-1:0] preset_i,
    output logic [W-1:0] count_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] count;
    } core_s;

    core_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op_i)
            OP_HOLD: st_d.count = st_q.count;
            OP_UP:   st_d.count = st_q.count + 1'b1;
            OP_LOAD: st_d.count = preset_i;
            OP_ZERO: st_d.count = '0;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign wrap_o  = (op_i == OP_UP) && (st_q.count == TOP);

    // R4: operating codes act on the next edge
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_HOLD) |=> $stable(count_o));
    a_r4_up: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_UP) |=> (count_o == W'($past(count_o) + 1'b1)));
    a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ZERO) |=> (count_o == '0));
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LOAD) |=> (count_o == $past(preset_i)));
endmodule

// File: rtl/cntp_flag.sv
module cntp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_s;

    flag_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.flag = 1'b1;
        else if (clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R7 / R9: a set always lands, even alongside a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R8: a clear without a set empties the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/cntp_regs.sv
module cntp_regs
    import cntp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] awaddr,
    input  logic          awvalid,
    output logic          awready,
    input  logic [DW-1:0] wdata,
    input  logic [DW/8-1:0] wstrb,
    input  logic          wvalid,
    output logic          wready,
    output logic [1:0]    bresp,
    output logic          bvalid,
    input  logic          bready,
    input  logic [AW-1:0] araddr,
    input  logic          arvalid,
    output logic          arready,
    output logic [DW-1:0] rdata,
    output logic [1:0]    rresp,
    output logic          rvalid,
    input  logic          rready,
    input  logic [CW-1:0] count_i,
    input  logic          flag_i,
    output logic [CW-1:0] preset_o,
    output op_e           op_o,
    output logic          clr_o
);
    localparam int NB = DW / 8;
    localparam int BL = $clog2(NB);
    localparam int IW = AW - BL;

    localparam logic [IW-1:0] IDX_PRESET = IW'(0);
    localparam logic [IW-1:0] IDX_OP     = IW'(1);
    localparam logic [IW-1:0] IDX_SCRATCH= IW'(2);
    localparam logic [IW-1:0] IDX_FLAG   = IW'(3);
    localparam int CLR_BIT = 1;

    typedef struct packed {
        logic [CW-1:0] preset;
        logic [DW-1:0] opw;
        logic [DW-1:0] scratch;
        logic          bvalid;
        logic          rvalid;
        logic [DW-1:0] rdata;
    } regs_s;

    regs_s st_d, st_q;

    logic [IW-1:0] widx, ridx;
    logic          wr_fire, rd_fire;
    logic [DW-1:0] merged_op, merged_scratch, merged_preset;
    logic          unused_lsbs;

    assign widx = awaddr[AW-1:BL];
    assign ridx = araddr[AW-1:BL];
    assign unused_lsbs = ^{awaddr[BL-1:0], araddr[BL-1:0], merged_preset[DW-1:CW]};

    assign awready = awvalid && wvalid && !st_q.bvalid;
    assign wready  = awready;
    assign arready = !st_q.rvalid;
    assign wr_fire = awready;
    assign rd_fire = arvalid && arready;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign merged_op[8*b +: 8]      = wstrb[b] ? wdata[8*b +: 8] : st_q.opw[8*b +: 8];
        assign merged_scratch[8*b +: 8] = wstrb[b] ? wdata[8*b +: 8] : st_q.scratch[8*b +: 8];
        assign merged_preset[8*b +: 8]  = wstrb[b] ? wdata[8*b +: 8] : DW'(st_q.preset) >> (8*b) & DW'(8'hFF);
    end

    always_comb begin
        st_d = st_q;
        if (wr_fire) begin
            unique case (widx)
                IDX_PRESET:  st_d.preset  = merged_preset[CW-1:0];
                IDX_OP:      st_d.opw     = merged_op;
                IDX_SCRATCH: st_d.scratch = merged_scratch;
                default: ;
            endcase
            st_d.bvalid = 1'b1;
        end else if (st_q.bvalid && bready) begin
            st_d.bvalid = 1'b0;
        end

        if (rd_fire) begin
            unique case (ridx)
                IDX_PRESET:  st_d.rdata = DW'(count_i);
                IDX_OP:      st_d.rdata = st_q.opw;
                IDX_SCRATCH: st_d.rdata = st_q.scratch;
                IDX_FLAG:    st_d.rdata = DW'(flag_i);
                default:     st_d.rdata = '0;
            endcase
            st_d.rvalid = 1'b1;
        end else if (st_q.rvalid && rready) begin
            st_d.rvalid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bvalid   = st_q.bvalid;
    assign rvalid   = st_q.rvalid;
    assign rdata    = st_q.rdata;
    assign bresp    = RESP_OKAY;
    assign rresp    = RESP_OKAY;
    assign preset_o = st_q.preset;
    assign op_o     = op_e'(st_q.opw[1:0]);
    assign clr_o    = wr_fire && (widx == IDX_FLAG) && wstrb[0] && wdata[CLR_BIT];

    // R10: responses persist until taken, one transfer in flight per channel
    a_r10_bhold: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);
    a_r10_rhold: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));
    a_r10_no_aw_while_b: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> !awready);
    a_r10_no_ar_while_r: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !arready);
endmodule

// File: rtl/cntp_top.sv
module cntp_top
    import cntp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   s_awaddr,
    input  logic            s_awvalid,
    output logic            s_awready,
    input  logic [DW-1:0]   s_wdata,
    input  logic [DW/8-1:0] s_wstrb,
    input  logic            s_wvalid,
    output logic            s_wready,
    output logic [1:0]      s_bresp,
    output logic            s_bvalid,
    input  logic            s_bready,
    input  logic [AW-1:0]   s_araddr,
    input  logic            s_arvalid,
    output logic            s_arready,
    output logic [DW-1:0]   s_rdata,
    output logic [1:0]      s_rresp,
    output logic            s_rvalid,
    input  logic            s_rready,
    output logic [CW-1:0]   led_o,
    output logic            irq_o
);
    logic [CW-1:0] count, preset;
    op_e           op;
    logic          wrap, clr, flag;

    cntp_regs #(.DW(DW), .CW(CW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .count_i(count), .flag_i(flag),
        .preset_o(preset), .op_o(op), .clr_o(clr)
    );

    cntp_core #(.W(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .op_i(op), .preset_i(preset),
        .count_o(count), .wrap_o(wrap)
    );

    cntp_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(wrap), .clr_i(clr), .flag_o(flag)
    );

    assign led_o = count;
    assign irq_o = flag;

    // R7: the interrupt follows a wrap on the next edge
    a_r7_wrap_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_UP && count == {CW{1'b1}}) |=> (irq_o && led_o == '0));
endmodule

// File: tb/cntp_top_tb.sv
module cntp_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid, irq;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic [7:0]  led;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cntp_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .led_o(led), .irq_o(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int word, logic [31:0] d, logic [3:0] s = 4'hF);
        @(negedge clk);
        awaddr = 7'(word * 4); wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
        @(posedge clk);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        chk("R10 bvalid after write", 32'(bvalid), 32'd1);
        chk("R10 bresp okay", 32'(bresp), 32'd0);
        @(posedge clk);
    endtask

    task automatic rd(int word, output logic [31:0] d);
        @(negedge clk);
        araddr = 7'(word * 4); arvalid = 1;
        @(posedge clk);
        @(negedge clk);
        arvalid = 0;
        d = rdata;
        chk("R10 rresp okay", 32'(rresp) | 32'(!rvalid) << 4, 32'd0);
        @(posedge clk);
    endtask

    task automatic t_reset();
        chk("R1 count", 32'(led), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 bvalid", 32'(bvalid), 0);
        chk("R1 rvalid", 32'(rvalid), 0);
    endtask

    task automatic t_load_read();
        logic [31:0] d;
        wr(0, 32'hFFFF_FF5A); wr(1, 2); wr(1, 0);
        @(negedge clk);
        chk("R5 led after load", 32'(led), 32'h5A);
        rd(0, d); chk("R3 word0 reads count zero-extended", d, 32'h5A);
        rd(1, d); chk("R6 word1 readback", d, 0);
    endtask

    task automatic t_count_up();
        wr(0, 32'h10); wr(1, 2); wr(1, 0);
        wr(1, 1); wr(1, 0);  // up for exactly two edges
        @(negedge clk);
        chk("R4 up two steps", 32'(led), 32'h12);
        repeat (3) @(negedge clk);
        chk("R4 hold keeps count", 32'(led), 32'h12);
        wr(1, 3); wr(1, 0);
        @(negedge clk);
        chk("R4 code 11 zeroes", 32'(led), 0);
    endtask

    task automatic t_strb_alias();
        logic [31:0] d;
        wr(2, 32'hDEAD_BEEF);
        wr(2, 32'h1122_3344, 4'b0001);
        rd(2, d); chk("R6 strb lane0 only", d, 32'hDEAD_BE44);
        wr(2, 32'h5566_7788, 4'b1000);
        rd(2, d); chk("R6 strb lane3 only", d, 32'h55AD_BE44);
        @(negedge clk);
        awaddr = 7'h0B; wdata = 32'h0000_00AB; wstrb = 4'hF; awvalid = 1; wvalid = 1; // word 2, low bits set
        @(posedge clk); @(negedge clk); awvalid = 0; wvalid = 0; @(posedge clk);
        rd(2, d); chk("R2 byte offset ignored", d, 32'h0000_00AB);
    endtask

    task automatic t_unimpl();
        logic [31:0] d;
        wr(0, 32'h33); wr(1, 2); wr(1, 0);
        for (int w = 4; w < 32; w += 9) wr(w, 32'hFFFF_FFFF);
        rd(4, d);  chk("R11 word4 reads zero", d, 0);
        rd(31, d); chk("R11 word31 reads zero", d, 0);
        rd(2, d);  chk("R11 word2 untouched", d, 32'h0000_00AB);
        rd(0, d);  chk("R11 count untouched", d, 32'h33);
    endtask

    task automatic t_rollover();
        logic [31:0] d;
        wr(0, 32'hFD); wr(1, 2); wr(1, 0);
        @(negedge clk);
        chk("R7 no wrap yet", 32'(irq), 0);
        wr(1, 1);
        repeat (6) @(negedge clk);
        wr(1, 0);
        @(negedge clk);
        chk("R7 irq after wrap", 32'(irq), 1);
        rd(3, d); chk("R7 word3 flag", d, 1);
        wr(3, 32'hFFFF_FFFD);
        @(negedge clk);
        chk("R8 bit1 zero does not clear", 32'(irq), 1);
        wr(3, 2);
        @(negedge clk);
        chk("R8 clear", 32'(irq), 0);
        rd(3, d); chk("R8 word3 reads clear", d, 0);
    endtask

    task automatic t_set_wins();
        wr(0, 32'hFE); wr(1, 2); wr(1, 0);
        wr(1, 1);   // up from 0xFE; the wrap falls on the clear's edge
        wr(3, 2);
        wr(1, 0);
        @(negedge clk);
        chk("R9 set wins over clear", 32'(irq), 1);
        chk("R7 count past wrap", 32'(led), 32'h02);
        wr(3, 2);
        @(negedge clk);
        chk("R8 clear after set", 32'(irq), 0);
    endtask

    task automatic t_hold_resp();
        logic [31:0] snap;
        bready = 0;
        @(negedge clk);
        awaddr = 7'h08; wdata = 32'hCAFE_0001; wstrb = 4'hF; awvalid = 1; wvalid = 1;
        @(posedge clk); @(negedge clk);
        wdata = 32'h0BAD_0BAD;
        repeat (3) @(negedge clk);
        chk("R10 bvalid held", 32'(bvalid), 1);
        chk("R10 no second write", 32'(awready), 0);
        awvalid = 0; wvalid = 0;
        bready = 1;
        @(negedge clk);
        chk("R10 bvalid drops", 32'(bvalid), 0);
        rready = 0;
        araddr = 7'h08; arvalid = 1;
        @(posedge clk); @(negedge clk);
        arvalid = 0;
        snap = rdata;
        repeat (3) @(negedge clk);
        chk("R10 rvalid held", 32'(rvalid), 1);
        chk("R10 rdata stable", rdata, snap);
        chk("R6 held write landed once", snap, 32'hCAFE_0001);
        rready = 1;
        @(negedge clk);
        chk("R10 rvalid drops", 32'(rvalid), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_load_read();
        t_count_up();
        t_strb_alias();
        t_unimpl();
        t_rollover();
        t_set_wins();
        t_hold_resp();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule